// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Sequencer

This block sits between a clocked system bus and an external asynchronous static RAM that has 18 address lines, 8 shared data lines, a pair of chip selects of opposite polarity (one active low, one active high), an active-low output enable and an active-low write enable. Each request on the system side is a single byte. A request is either a read or a write and uses a valid/ready handshake. The controller plays out the pin sequence for that request and holds every memory-side signal in a register. Read data comes back as a one-cycle response pulse.

All analog limits of the memory are given in nanoseconds as parameters. Each limit becomes a cycle count: the ceiling of the limit divided by the clock period, and never less than one cycle. A write is ended by the rising edge of the write strobe while the chip stays selected, and the output enable stays high for the whole write. After every read the controller waits a number of turnaround cycles before it drives the data lines again. It also has a standby input. Standby deselects the memory between accesses, and on exit the memory stays deselected for one full read cycle before the next access is allowed.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held, and until the synchronised reset is released, the chip is deselected (`mem_ce1_n`=1, `mem_ce2`=0), `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `req_ready`=0 and `rsp_valid`=0.
- R2: The memory is selected (`mem_ce1_n`=0 together with `mem_ce2`=1) only while a read or write is in progress. At all other times both selects sit in their inactive levels.
- R3: A write holds `mem_we_n` low for NW = max(c(tPWE), c(tAW), c(tSD), max(c(tWC)-1, 1)) cycles, where c(t) = max(1, ceil(t/CLK_NS)). During those cycles the chip is selected, `mem_oe_n` is high, `mem_dq_oe` is 1, and address and data do not change. One more cycle follows with `mem_we_n` high, the chip still selected and address and data unchanged, so the write ends on the write-strobe edge.
- R4: A read holds the chip selected with `mem_oe_n` low, `mem_we_n` high and `mem_dq_oe` 0 for NR = max(c(tAA), c(tDOE), c(tRC)) cycles. The controller samples `mem_dq_i` at the clock edge that ends this window. `rsp_valid` is then high for exactly one cycle, NR edges after the accepting edge, with the sampled byte on `rsp_rdata`.
- R5: After a read, the controller spends NT = c(tHZ) cycles with `mem_oe_n` high, the chip deselected and `mem_dq_oe` 0. `mem_dq_oe` is never 1 until at least tHZ ns have passed since `mem_oe_n` last went high.
- R6: `req_ready` is 1 only when the controller is idle, out of reset, and `sby_req` is 0. A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1, and its address and write data are captured at that edge. Later changes on `req_addr` and `req_wdata` have no effect on the access. `req_ready` returns NW+1 edges after a write is accepted and NR+NT edges after a read is accepted.
- R7: When `sby_req` is 1 while the controller is idle, the memory stays deselected and `req_ready` stays 0, so requests presented during standby start no access. After `sby_req` falls, the memory stays deselected for NREC = c(tRC) cycles, and `req_ready` rises NREC edges after the edge that sees `sby_req` low.
- R8: A read returns the byte most recently written to the same address by an earlier write, for any pattern of addresses, data and interleaved standby periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read byte |
| sby_req | input | 1 | Standby request (level) |
| mem_addr | output | 18 | Memory address lines |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_i | input | 8 | Data received from the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |

## Verification
With the default 8 ns clock and 55 ns grade, the memory pins change at the accepting edge itself. From that edge, a write keeps the strobe low for 7 cycles, and `req_ready` comes back 8 edges later. For a read, the response pulse comes 7 edges after acceptance and `req_ready` 11 edges after it. Leaving standby takes 7 edges. The bench counts falling edges from the accepting edge, so each pin level, the response and the ready return are checked in the exact cycle where they are due, and the pins are checked in every cycle of the access. The memory model on the bench returns valid data only after the full access time has passed. It also records how long each write strobe is held and checks that the controller does not drive the data lines while the memory may still be driving them, so an access that ends one cycle early shows up as wrong data or a timing failure.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WR   = 3'd1,
    ST_WEND = 3'd2,
    ST_RD   = 3'd3,
    ST_TURN = 3'd4,
    ST_SBY  = 3'd5,
    ST_REC  = 3'd6
  } seq_state_e;

  // ceiling of ns / period, never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per_ns);
    int unsigned c;
    c = (ns + per_ns - 1) / per_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
`timescale 1ns/1ps
module sram_ctrl_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned N_WP  = 7,
  parameter int unsigned N_RD  = 7,
  parameter int unsigned N_TA  = 4,
  parameter int unsigned N_REC = 7,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             sby_req,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             req_ready,
  output logic             accept,
  output logic             sample,
  output logic             mem_ce1_n,
  output logic             mem_ce2,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic             mem_dq_oe
);

  localparam int unsigned GAP_MAX = N_TA + 1;
  localparam int unsigned GW      = $clog2(GAP_MAX + 1);

  seq_state_e state_q, state_d;
  logic       sel_d, we_n_d, oe_n_d, dq_oe_d;

  assign req_ready = rst_n && (state_q == ST_IDLE) && !sby_req;
  assign accept    = req_ready && req_valid;
  assign sample    = (state_q == ST_RD) && tmr_done;

  // next state
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (sby_req) begin
          state_d = ST_SBY;
        end else if (accept) begin
          tmr_load = 1'b1;
          if (req_write) begin
            state_d = ST_WR;
            tmr_val = CNT_W'(N_WP - 1);
          end else begin
            state_d = ST_RD;
            tmr_val = CNT_W'(N_RD - 1);
          end
        end
      end
      ST_WR:   if (tmr_done) state_d = ST_WEND;
      ST_WEND: state_d = ST_IDLE;
      ST_RD: begin
        if (tmr_done) begin
          state_d  = ST_TURN;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(N_TA - 1);
        end
      end
      ST_TURN: if (tmr_done) state_d = ST_IDLE;
      ST_SBY: begin
        if (!sby_req) begin
          state_d  = ST_REC;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(N_REC - 1);
        end
      end
      ST_REC:  if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // pin decode of the next state, registered below
  always_comb begin
    sel_d   = (state_d == ST_WR) || (state_d == ST_WEND) || (state_d == ST_RD);
    we_n_d  = (state_d != ST_WR);
    oe_n_d  = (state_d != ST_RD);
    dq_oe_d = (state_d == ST_WR) || (state_d == ST_WEND);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mem_ce1_n <= 1'b1;
      mem_ce2   <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      state_q   <= state_d;
      mem_ce1_n <= !sel_d;
      mem_ce2   <= sel_d;
      mem_we_n  <= we_n_d;
      mem_oe_n  <= oe_n_d;
      mem_dq_oe <= dq_oe_d;
    end
  end

  // checker counter: cycles since output enable was last low
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    gap_q <= GW'(GAP_MAX);
    else if (!mem_oe_n)            gap_q <= '0;
    else if (gap_q != GW'(GAP_MAX)) gap_q <= gap_q + 1'b1;
  end

  // R2
  sel_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce1_n == !mem_ce2);

  // R3
  wr_end_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce1_n && mem_ce2 && mem_dq_oe));

  // R3
  wr_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce1_n));

  // R4
  rd_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe && !mem_ce1_n));

  // R5
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (gap_q >= GW'(N_TA)));

  // R6
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_we_n && mem_oe_n && !mem_dq_oe && mem_ce1_n));

  // R7
  sby_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SBY) |-> (mem_ce1_n && !mem_ce2 && !req_ready));

endmodule

// File: rtl/sram_ctrl_dpath.sv
`timescale 1ns/1ps
module sram_ctrl_dpath #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              sample,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (sample) rdata_q <= mem_dq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= sample;
  end

  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign rsp_valid = vld_q;
  assign rsp_rdata = rdata_q;

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CLK_NS = 8,
  parameter int unsigned T_WC   = 55,
  parameter int unsigned T_PWE  = 50,
  parameter int unsigned T_AW   = 45,
  parameter int unsigned T_SD   = 25,
  parameter int unsigned T_RC   = 55,
  parameter int unsigned T_AA   = 55,
  parameter int unsigned T_DOE  = 30,
  parameter int unsigned T_HZ   = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              sby_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n
);

  localparam int unsigned N_WP = max2(
    max2(ns_to_cyc(T_PWE, CLK_NS), ns_to_cyc(T_AW, CLK_NS)),
    max2(ns_to_cyc(T_SD, CLK_NS), max2(ns_to_cyc(T_WC, CLK_NS) - 1, 1)));
  localparam int unsigned N_RD = max2(
    max2(ns_to_cyc(T_AA, CLK_NS), ns_to_cyc(T_DOE, CLK_NS)), ns_to_cyc(T_RC, CLK_NS));
  localparam int unsigned N_TA  = ns_to_cyc(T_HZ, CLK_NS);
  localparam int unsigned N_REC = ns_to_cyc(T_RC, CLK_NS);
  localparam int unsigned N_MAX = max2(max2(N_WP, N_RD), max2(N_TA, N_REC));
  localparam int unsigned CNT_W = $clog2(N_MAX + 1);

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic             tmr_load, tmr_done, accept, sample;
  logic [CNT_W-1:0] tmr_val;

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_ctrl_seq #(
    .N_WP (N_WP), .N_RD (N_RD), .N_TA (N_TA), .N_REC (N_REC), .CNT_W (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .sby_req   (sby_req),
    .tmr_done  (tmr_done),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .req_ready (req_ready),
    .accept    (accept),
    .sample    (sample),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
  );

  sram_ctrl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .sample    (sample),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

  // R1
  rst_idle_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (!req_ready && !rsp_valid));

endmodule

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;

  localparam int unsigned CLK = 8;
  localparam int unsigned TPWE = 50, TAW = 45, TSD = 25, TWC = 55;
  localparam int unsigned TRC = 55, TAA = 55, TDOE = 30, THZ = 25;

  function automatic int unsigned cyc(input int unsigned ns);
    int unsigned c;
    c = (ns + CLK - 1) / CLK;
    return (c == 0) ? 1 : c;
  endfunction
  function automatic int unsigned mx(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
  function automatic int unsigned exp_nw();
    return mx(mx(cyc(TPWE), cyc(TAW)), mx(cyc(TSD), mx(cyc(TWC) - 1, 1)));
  endfunction
  function automatic int unsigned exp_nr();
    return mx(mx(cyc(TAA), cyc(TDOE)), cyc(TRC));
  endfunction

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write, rsp_valid, sby_req;
  logic [17:0] req_addr, mem_addr;
  logic [7:0]  req_wdata, rsp_rdata, mem_dq_o, mem_dq_i;
  logic        mem_dq_oe, mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n;

  sram_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sby_req(sby_req),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i),
    .mem_dq_oe(mem_dq_oe), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] model_mem [int unsigned];
  logic [7:0] exp_mem   [int unsigned];
  logic [7:0] drv_byte;
  bit         drv_ok;
  int         rd_cnt, since_rd, we_cnt;
  logic [17:0] w_addr;
  logic [7:0]  w_data;
  bit          w_ok;

  assign mem_dq_i = drv_ok ? drv_byte : 8'hEE;

  always @(negedge clk) begin
    bit sel, rd_act;
    sel    = !mem_ce1_n && mem_ce2;
    rd_act = sel && !mem_oe_n && mem_we_n;
    if (!rst_n) begin
      rd_cnt = 0; since_rd = 99; we_cnt = 0; drv_ok = 0;
    end else begin
      if (rd_act) begin
        rd_cnt++; since_rd = 0;
      end else begin
        rd_cnt = 0;
        if (since_rd < 99) since_rd++;
      end
      drv_ok   = rd_act && (rd_cnt * CLK >= mx(TAA, TDOE));
      drv_byte = model_mem.exists(mem_addr) ? model_mem[mem_addr] : 8'h00;
      // R5: no driving while the memory may still drive
      if (mem_dq_oe)
        check(since_rd >= 1 && (since_rd - 1) * CLK >= THZ, "R5",
              "drive too soon after read (ns)", (since_rd - 1) * CLK, THZ);
      // R2: never selected with neither strobe low outside accesses is fine; selection needs a strobe or a write end
      if (sel && !mem_we_n) begin
        if (we_cnt == 0) begin
          w_addr = mem_addr; w_data = mem_dq_o; w_ok = mem_dq_oe && mem_oe_n;
        end else if (mem_addr != w_addr || mem_dq_o != w_data || !mem_dq_oe || !mem_oe_n) begin
          w_ok = 0;
        end
        we_cnt++;
      end else if (we_cnt > 0) begin
        check(sel && mem_we_n, "R3", "write not ended by strobe edge", int'(sel), 1);
        check(w_ok && mem_addr == w_addr && mem_dq_o == w_data && mem_dq_oe, "R3",
              "addr/data unstable in write", int'(w_ok), 1);
        check(we_cnt * CLK >= mx(TPWE, mx(TAW, TSD)), "R3", "strobe low ns",
              we_cnt * CLK, mx(TPWE, mx(TAW, TSD)));
        model_mem[w_addr] = w_data;
        we_cnt = 0;
      end
    end
  end

  // ---------------- operations ----------------
  task automatic run_op(input bit wr, input logic [17:0] a, input logic [7:0] d);
    int j, rsp_j, rsp_n, nw, nr, nt, ready_j;
    bit pins_ok;
    logic [7:0] got;
    nw = exp_nw(); nr = exp_nr(); nt = cyc(THZ);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_addr = 18'($urandom); req_wdata = 8'($urandom);
    pins_ok = 1; rsp_j = -1; rsp_n = 0; ready_j = -1; got = 0;
    for (j = 0; j < 60; j++) begin
      if (req_ready) begin ready_j = j; break; end
      if (rsp_valid) begin rsp_n++; rsp_j = j; got = rsp_rdata; end
      if (wr) begin
        if (j < nw)
          pins_ok &= !mem_we_n && mem_oe_n && mem_dq_oe && !mem_ce1_n && mem_ce2;
        else if (j == nw)
          pins_ok &= mem_we_n && mem_oe_n && mem_dq_oe && !mem_ce1_n && mem_ce2;
      end else begin
        if (j < nr)
          pins_ok &= !mem_oe_n && mem_we_n && !mem_dq_oe && !mem_ce1_n && mem_ce2;
        else
          pins_ok &= mem_oe_n && mem_we_n && !mem_dq_oe && mem_ce1_n && !mem_ce2;
      end
      @(negedge clk);
    end
    if (wr) begin
      check(pins_ok, "R3", "write pin sequence", int'(pins_ok), 1);
      check(ready_j == nw + 1, "R6", "write ready return edge", ready_j, nw + 1);
      exp_mem[a] = d;
    end else begin
      check(pins_ok, "R4", "read/turnaround pin sequence (R5)", int'(pins_ok), 1);
      check(rsp_n == 1 && rsp_j == nr, "R4", "response edge", rsp_j, nr);
      check(ready_j == nr + nt, "R6", "read ready return edge", ready_j, nr + nt);
      check(got == (exp_mem.exists(a) ? exp_mem[a] : 8'h00), "R8", "read data",
            got, exp_mem.exists(a) ? exp_mem[a] : 8'h00);
    end
  endtask

  task automatic run_standby(input int hold, input bit poke, input logic [17:0] a);
    int x;
    bit quiet;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    sby_req = 1;
    @(negedge clk);
    quiet = 1;
    for (int k = 0; k < hold; k++) begin
      if (poke) begin req_valid = 1; req_write = 1; req_addr = a; req_wdata = 8'h5A; end
      quiet &= !req_ready && mem_we_n && mem_oe_n && mem_ce1_n && !mem_ce2 && !mem_dq_oe;
      @(negedge clk);
    end
    req_valid = 0;
    check(quiet, "R7", "standby deselected, no access", int'(quiet), 1);
    sby_req = 0;
    @(negedge clk);
    quiet = 1;
    for (x = 0; x < 40; x++) begin
      if (req_ready) break;
      quiet &= mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n;
      @(negedge clk);
    end
    check(quiet, "R7", "recovery deselected", int'(quiet), 1);
    check(x == cyc(TRC), "R7", "recovery length", x, cyc(TRC));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R6 watchdog expired actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    int seed;
    seed = int'($urandom(32'h5EED_0042));
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; sby_req = 0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe, "R1",
          "pins in reset", int'(mem_ce1_n), 1);
    check(!req_ready && !rsp_valid, "R1", "ready/rsp in reset", int'(req_ready), 0);
    rst_n = 1;
    @(negedge clk);
    check(!req_ready, "R1", "ready held during reset sync", int'(req_ready), 0);
    repeat (3) @(negedge clk);
    check(req_ready, "R6", "ready after reset", int'(req_ready), 1);
    check(mem_ce1_n && !mem_ce2, "R2", "idle deselected", int'(mem_ce1_n), 1);

    // directed corners
    run_op(1, 18'h00000, 8'hA5);
    run_op(1, 18'h3FFFF, 8'h3C);
    run_op(0, 18'h00000, 8'h00);
    run_op(0, 18'h3FFFF, 8'h00);
    run_op(1, 18'h3FFFF, 8'hFF);   // overwrite
    run_op(0, 18'h3FFFF, 8'h00);
    run_op(0, 18'h12345, 8'h00);   // never written
    run_op(1, 18'h00001, 8'h00);
    run_op(0, 18'h00001, 8'h00);
    run_standby(5, 1, 18'h00000);  // poke write during standby
    run_op(0, 18'h00000, 8'h00);   // still A5
    run_standby(1, 0, 18'h0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [17:0] a;
      int r;
      r = int'($urandom % 100);
      a = (r < 10) ? 18'h3FFFF : (r < 20) ? 18'h00000 : 18'(18'h20000 + ($urandom % 16));
      if (r >= 97) run_standby(1 + int'($urandom % 4), 1, a);
      else run_op($urandom % 2 == 1, a, 8'($urandom));
    end

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule